// File: doc/BRIEF.md
# Calendar Clock with Daylight-Saving Shift

This block is the timekeeping core of a real-time clock. A clock enable that pulses at the low-frequency timebase rate (32.768 kHz by default) is divided down to one event per second. That event steps a chain of packed-BCD counters for seconds, minutes, hours, day of month, month, two-digit year and day of week. Month lengths and leap years are handled for the years 2000 to 2099.

Two programmable rules move the hour for daylight saving time. Each rule names a month, a weekday, a week of the month and an hour. A forward rule makes the clock skip the named hour. A backward rule repeats the preceding hour once per year.

The host sets the time and the rules through a simple addressed write port. It reads the time back through a shadow copy that is captured on request, so all seven fields of one read come from the same instant.

Top module: `rtc_dst_core`

## Requirements
- R1: `sec_tick` pulses for one cycle, only in a cycle where `tick_en` is high, on every PRESCALE-th `tick_en` pulse counted from reset or from the last time write. While `tick_en` stays low, the time does not change.
- R2: Seconds and minutes count 00 to 59 in BCD and carry into the next field. Hours count 00 to 23 and carry into the date.
- R3: The last day is 31 for months 01, 03, 05, 07, 08, 10 and 12, and 30 for months 04, 06, 09 and 11. February ends on 29 when the BCD year is divisible by 4 (00 counts as a leap year) and on 28 otherwise. The day after the last day is 01 of the next month. After 31 December the month becomes 01 and the year steps, with 99 wrapping to 00.
- R4: The day of week (0 to 6) advances by one at each midnight and wraps from 6 to 0.
- R5: A write to a time address (0 to 6) loads that field at the next clock edge. In the same cycle it restarts the prescaler, so the next second comes a full PRESCALE `tick_en` pulses later. A time write has priority over a second event in the same cycle.
- R6: Address map: 0 second, 1 minute, 2 hour (24 h), 3 date, 4 month, 5 year (all BCD), 6 day of week in bits 2:0. Addresses 7, 8, 9 hold the forward rule (month, rule byte, hour). Addresses 10, 11, 12 hold the backward rule in the same layout. Rule registers read back live. Other addresses read 00.
- R7: When a forward rule matches as the clock rolls from minute 59 of hour H-1 into hour H, the clock lands on H+1:00:00 instead (forward hour 01 to 22).
- R8: When a backward rule matches as the clock rolls into its hour H, the clock returns to H-1:00:00 and a done flag is set. While the flag is set the rule is ignored, and time writes do not clear the flag. The flag clears at the year rollover.
- R9: Rule byte: bit 7 enables the rule, bits 6:4 give the week of month n (1 to 5, which matches dates 7n-6 to 7n), and bits 2:0 give the weekday. A rule matches only when the month, weekday, week and target hour all agree and bit 7 is set.
- R10: A pulse on `rd_snap` copies all seven time fields into a shadow. Reads of addresses 0 to 6 return the shadow, which changes only on the next `rd_snap`.
- R11: After reset the time is 00:00:00 on 01-01-00 with weekday 6, both rules are disabled (all rule bytes 00), and the prescaler is at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timebase enable, one pulse per timebase period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data |
| rd_snap | input | 1 | Capture the live time into the read shadow |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Read data (combinational from the shadow or the rule registers) |
| sec_tick | output | 1 | One-cycle pulse on each second event |

## Verification
A wrong carry or month-length decision shows at the ports as a wrong field. It appears in the next snapshot taken after the second in which the bad boundary was crossed, which is one second event after the stimulus. A prescaler that is not cleared by a write shows up as a second that arrives fewer than PRESCALE pulses after the write. A done flag that fails to set, fails to clear or clears too early shows up as a hour that is repeated twice in one year, or not repeated in the next year. Each of these is seen one second after the crossing that exposes it.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int A_SEC  = 0;
  localparam int A_MIN  = 1;
  localparam int A_HOUR = 2;
  localparam int A_DATE = 3;
  localparam int A_MON  = 4;
  localparam int A_YEAR = 5;
  localparam int A_DOW  = 6;
  localparam int A_FWD  = 7;
  localparam int A_BACK = 10;
  localparam int RULE_REGS = 3;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] date;
    logic [7:0] hour;
    logic [7:0] minute;
    logic [7:0] second;
    logic [2:0] dow;
  } rtc_time_t;

  localparam rtc_time_t RESET_TIME = '{year: 8'h00, month: 8'h01, date: 8'h01,
                                        hour: 8'h00, minute: 8'h00, second: 8'h00,
                                        dow: 3'd6};

  function automatic logic [6:0] bcd2bin(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [6:0] v);
    logic [6:0] t;
    logic [6:0] o;
    t = v / 7'd10;
    o = v % 7'd10;
    return {t[3:0], o[3:0]};
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] b);
    return bin2bcd(bcd2bin(b) + 7'd1);
  endfunction

  function automatic logic year_is_leap(input logic [7:0] yr);
    logic [6:0] y;
    y = bcd2bin(yr);
    return (y[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02: return year_is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  function automatic logic [2:0] week_of(input logic [7:0] date);
    logic [6:0] w;
    w = (bcd2bin(date) - 7'd1) / 7'd7 + 7'd1;
    return w[2:0];
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768,
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          clear,
  output logic          sec_tick,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  assign sec_tick = tick_en && !clear && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clear)   cnt <= '0;
    else if (tick_en) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/rtc_dst_rule.sv
module rtc_dst_rule
  import rtc_pkg::*;
#(
  parameter int AW   = 4,
  parameter int BASE = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [7:0]    cur_month,
  input  logic [7:0]    cur_date,
  input  logic [2:0]    cur_dow,
  input  logic [7:0]    cand_hour,
  output logic          hit,
  output logic [23:0]   cfg
);
  logic [7:0] mon_q, rule_q, hour_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_q  <= '0;
      rule_q <= '0;
      hour_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(BASE))     mon_q  <= wr_data;
      if (wr_addr == AW'(BASE + 1)) rule_q <= wr_data;
      if (wr_addr == AW'(BASE + 2)) hour_q <= wr_data;
    end
  end

  assign hit = rule_q[7]
            && (cur_month == mon_q)
            && (cur_dow == rule_q[2:0])
            && (week_of(cur_date) == rule_q[6:4])
            && (cand_hour == hour_q);

  assign cfg = {mon_q, rule_q, hour_q};
endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_tick,
  input  logic          wr_time,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          fwd_hit,
  input  logic          back_hit,
  output rtc_time_t     time_q,
  output logic [7:0]    cand_hour,
  output logic          fwd_apply,
  output logic          back_apply,
  output logic          dst_done
);
  logic       s59, m59, h23;
  logic       sec_roll, hour_step, day_roll, mon_roll, yr_roll;
  logic [7:0] last_day;

  always_comb begin
    s59       = (time_q.second == 8'h59);
    m59       = (time_q.minute == 8'h59);
    h23       = (time_q.hour == 8'h23);
    last_day  = month_last(time_q.month, time_q.year);
    sec_roll  = sec_tick && !wr_time && s59;
    hour_step = sec_roll && m59;
    day_roll  = hour_step && h23;
    mon_roll  = day_roll && (time_q.date == last_day);
    yr_roll   = mon_roll && (time_q.month == 8'h12);
    cand_hour = h23 ? 8'h00 : bcd_inc(time_q.hour);
    fwd_apply  = hour_step && !h23 && fwd_hit;
    back_apply = hour_step && !h23 && !fwd_hit && back_hit && !dst_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q   <= RESET_TIME;
      dst_done <= 1'b0;
    end else if (wr_time) begin
      case (wr_addr)
        AW'(A_SEC):  time_q.second <= wr_data;
        AW'(A_MIN):  time_q.minute <= wr_data;
        AW'(A_HOUR): time_q.hour   <= wr_data;
        AW'(A_DATE): time_q.date   <= wr_data;
        AW'(A_MON):  time_q.month  <= wr_data;
        AW'(A_YEAR): time_q.year   <= wr_data;
        default:     time_q.dow    <= wr_data[2:0];
      endcase
    end else if (sec_tick) begin
      time_q.second <= s59 ? 8'h00 : bcd_inc(time_q.second);
      if (sec_roll)
        time_q.minute <= m59 ? 8'h00 : bcd_inc(time_q.minute);
      if (hour_step)
        time_q.hour <= fwd_apply  ? bcd_inc(cand_hour) :
                       back_apply ? time_q.hour : cand_hour;
      if (day_roll) begin
        time_q.dow  <= (time_q.dow == 3'd6) ? 3'd0 : time_q.dow + 3'd1;
        time_q.date <= (time_q.date == last_day) ? 8'h01 : bcd_inc(time_q.date);
      end
      if (mon_roll)
        time_q.month <= (time_q.month == 8'h12) ? 8'h01 : bcd_inc(time_q.month);
      if (yr_roll)
        time_q.year <= (time_q.year == 8'h99) ? 8'h00 : bcd_inc(time_q.year);
      if (yr_roll)         dst_done <= 1'b0;
      else if (back_apply) dst_done <= 1'b1;
    end
  end
endmodule

// File: rtl/rtc_read_port.sv
module rtc_read_port
  import rtc_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_snap,
  input  rtc_time_t     live,
  input  logic [AW-1:0] rd_addr,
  input  logic [23:0]   fwd_cfg,
  input  logic [23:0]   back_cfg,
  output logic [7:0]    rd_data,
  output rtc_time_t     shadow_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       shadow_q <= RESET_TIME;
    else if (rd_snap) shadow_q <= live;
  end

  always_comb begin
    case (rd_addr)
      AW'(A_SEC):      rd_data = shadow_q.second;
      AW'(A_MIN):      rd_data = shadow_q.minute;
      AW'(A_HOUR):     rd_data = shadow_q.hour;
      AW'(A_DATE):     rd_data = shadow_q.date;
      AW'(A_MON):      rd_data = shadow_q.month;
      AW'(A_YEAR):     rd_data = shadow_q.year;
      AW'(A_DOW):      rd_data = {5'b0, shadow_q.dow};
      AW'(A_FWD):      rd_data = fwd_cfg[23:16];
      AW'(A_FWD + 1):  rd_data = fwd_cfg[15:8];
      AW'(A_FWD + 2):  rd_data = fwd_cfg[7:0];
      AW'(A_BACK):     rd_data = back_cfg[23:16];
      AW'(A_BACK + 1): rd_data = back_cfg[15:8];
      AW'(A_BACK + 2): rd_data = back_cfg[7:0];
      default:         rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtc_dst_core.sv
module rtc_dst_core
  import rtc_pkg::*;
#(
  parameter int PRESCALE = 32768,
  parameter int AW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          rd_snap,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          sec_tick
);
  localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int NRULE = 2;

  logic            wr_time;
  logic [CW-1:0]   presc_cnt;
  logic            presc_idle;
  rtc_time_t       time_q;
  rtc_time_t       shadow_q;
  logic [7:0]      cand_hour;
  logic            fwd_apply, back_apply, dst_done;
  logic [NRULE-1:0] rule_hit;
  logic [23:0]     rule_cfg [NRULE];

  assign wr_time    = wr_en && (wr_addr <= AW'(A_DOW));
  assign presc_idle = (presc_cnt == '0);

  rtc_prescaler #(.DIV(PRESCALE)) presc_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .clear(wr_time),
    .sec_tick(sec_tick), .cnt(presc_cnt)
  );

  for (genvar g = 0; g < NRULE; g++) begin : g_rule
    rtc_dst_rule #(.AW(AW), .BASE(A_FWD + RULE_REGS * g)) rule_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .cur_month(time_q.month), .cur_date(time_q.date), .cur_dow(time_q.dow),
      .cand_hour(cand_hour), .hit(rule_hit[g]), .cfg(rule_cfg[g])
    );
  end

  rtc_time_counter #(.AW(AW)) cnt_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_time(wr_time),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .fwd_hit(rule_hit[0]), .back_hit(rule_hit[1]),
    .time_q(time_q), .cand_hour(cand_hour),
    .fwd_apply(fwd_apply), .back_apply(back_apply), .dst_done(dst_done)
  );

  rtc_read_port #(.AW(AW)) rd_i (
    .clk(clk), .rst_n(rst_n), .rd_snap(rd_snap), .live(time_q), .rd_addr(rd_addr),
    .fwd_cfg(rule_cfg[0]), .back_cfg(rule_cfg[1]),
    .rd_data(rd_data), .shadow_q(shadow_q)
  );
endmodule

// File: rtl/rtc_dst_core_chk.sv
module rtc_dst_core_chk
  import rtc_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      tick_en,
  input logic      sec_tick,
  input logic      wr_time,
  input logic      presc_idle,
  input rtc_time_t time_q,
  input rtc_time_t shadow_q,
  input logic      rd_snap,
  input logic      fwd_apply,
  input logic      back_apply,
  input logic      dst_done
);
  assert_tick_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> tick_en);

  assert_write_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_time |=> presc_idle);

  assert_hold_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !wr_time) |=> $stable(time_q));

  assert_sec_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !wr_time && time_q.second != 8'h59)
      |=> bcd2bin(time_q.second) == bcd2bin($past(time_q.second)) + 7'd1);

  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !wr_time && time_q.second == 8'h59) |=> time_q.second == 8'h00);

  assert_fwd_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_apply |=> time_q.hour == bcd_inc(bcd_inc($past(time_q.hour))));

  assert_back_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    back_apply |=> (dst_done && time_q.hour == $past(time_q.hour)));

  assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_snap |=> $stable(shadow_q));
endmodule

bind rtc_dst_core rtc_dst_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sec_tick(sec_tick),
  .wr_time(wr_time), .presc_idle(presc_idle), .time_q(time_q),
  .shadow_q(shadow_q), .rd_snap(rd_snap), .fwd_apply(fwd_apply),
  .back_apply(back_apply), .dst_done(dst_done)
);

// File: tb/rtc_dst_core_tb_top.sv
module rtc_dst_core_tb_top;
  localparam int PS = 4;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          rd_snap = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          sec_tick;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  rtc_dst_core #(.PRESCALE(PS), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_snap(rd_snap), .rd_addr(rd_addr), .rd_data(rd_data),
    .sec_tick(sec_tick)
  );

  // {start yr mo dt hr mn sc dw, seconds to run, expected yr mo dt hr mn sc dw}
  localparam int NV = 13;
  localparam logic [127:0] VEC [NV] = '{
    {56'h00010100000006, 16'd1,  56'h00010100000106}, // R2 plain second
    {56'h23061512345903, 16'd1,  56'h23061512350003}, // R2 minute carry
    {56'h23013123595902, 16'd1,  56'h23020100000003}, // R3 31-day month, R4
    {56'h23022823595902, 16'd1,  56'h23030100000003}, // R3 Feb common year
    {56'h24022823595903, 16'd1,  56'h24022900000004}, // R3 Feb leap year
    {56'h24022923595904, 16'd1,  56'h24030100000005}, // R3 leap day end
    {56'h25043023595903, 16'd1,  56'h25050100000004}, // R3 30-day month
    {56'h99123123595906, 16'd1,  56'h00010100000000}, // R3 year wrap, R4 6->0
    {56'h00022823595901, 16'd1,  56'h00022900000002}, // R3 year 00 leap
    {56'h21093023595906, 16'd1,  56'h21100100000000}, // R3 Sep end, R4 wrap
    {56'h22070410595901, 16'd61, 56'h22070411010001}, // R2 hour carry
    {56'h22083109593003, 16'd45, 56'h22083110001503}, // R2 run across hour
    {56'h22113023595903, 16'd1,  56'h22120100000004}  // R3 Nov end
  };

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_time(input logic [55:0] t);
    wr(5, t[55:48]); wr(4, t[47:40]); wr(3, t[39:32]); wr(2, t[31:24]);
    wr(1, t[23:16]); wr(0, t[15:8]); wr(6, t[7:0]);
  endtask

  task automatic run_cycles(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic run_secs(input int n);
    run_cycles(n * PS);
  endtask

  task automatic pulse_sparse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic snap();
    @(negedge clk); rd_snap = 1'b1;
    @(negedge clk); rd_snap = 1'b0;
  endtask

  task automatic peek(input int a, output logic [7:0] v);
    rd_addr = AW'(a);
    #1;
    v = rd_data;
  endtask

  task automatic read_all(output logic [55:0] t);
    logic [7:0] b;
    snap();
    peek(5, b); t[55:48] = b;
    peek(4, b); t[47:40] = b;
    peek(3, b); t[39:32] = b;
    peek(2, b); t[31:24] = b;
    peek(1, b); t[23:16] = b;
    peek(0, b); t[15:8]  = b;
    peek(6, b); t[7:0]   = b;
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_case(input string req, input logic [55:0] st, input int n,
                          input logic [55:0] exp);
    logic [55:0] got;
    set_time(st);
    run_secs(n);
    read_all(got);
    check(req, 64'(got), 64'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [55:0] t;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    read_all(t);
    check("R11 reset time", 64'(t), 64'h00010100000006);
    peek(8, b);
    check("R11 rule disabled", 64'(b), 64'h0);

    // R1 no advance while tick_en low
    repeat (50) @(negedge clk);
    read_all(t);
    check("R1 idle hold", 64'(t), 64'h00010100000006);

    // R2 R3 R4 vector table
    for (int i = 0; i < NV; i++)
      run_case("R2/R3/R4 table", VEC[i][127:72], int'(VEC[i][71:56]), VEC[i][55:0]);

    // R1 sparse pulses: PS-1 pulses give no second, the PS-th does
    set_time(56'h30050508000002);
    pulse_sparse(PS - 1);
    read_all(t);
    check("R1 partial count", 64'(t[15:8]), 64'h00);
    pulse_sparse(1);
    read_all(t);
    check("R1 full count", 64'(t[15:8]), 64'h01);

    // R5 write restarts prescaler
    set_time(56'h30050508000002);
    run_cycles(2);
    wr(0, 8'h20);
    run_cycles(PS - 1);
    read_all(t);
    check("R5 no early second", 64'(t[15:8]), 64'h20);
    run_cycles(1);
    read_all(t);
    check("R5 second after full period", 64'(t[15:8]), 64'h21);

    // R10 shadow coherence
    set_time(56'h30060112000003);
    snap();
    run_secs(1);
    peek(0, b);
    check("R10 shadow holds", 64'(b), 64'h00);
    snap();
    peek(0, b);
    check("R10 shadow refresh", 64'(b), 64'h01);

    // R6 rule register readback; program rules
    wr(7, 8'h03); wr(8, 8'hA0); wr(9, 8'h02);   // forward: Mar, week 2, dow 0, 02h
    wr(10, 8'h11); wr(11, 8'h90); wr(12, 8'h02); // backward: Nov, week 1, dow 0, 02h
    peek(7, b);  check("R6 fwd month", 64'(b), 64'h03);
    peek(11, b); check("R6 back rule", 64'(b), 64'h90);
    peek(13, b); check("R6 unmapped", 64'(b), 64'h00);

    // R7 forward shift
    run_case("R7 forward skip", 56'h24031001595900, 1, 56'h24031003000000);
    // R9 week and weekday mismatches
    run_case("R9 week mismatch", 56'h24030301595900, 1, 56'h24030302000000);
    run_case("R9 dow mismatch", 56'h24031101595901, 1, 56'h24031102000001);

    // R8 backward shift once
    run_case("R8 backward repeat", 56'h24110301595900, 1, 56'h24110301000000);
    run_secs(3600);
    read_all(t);
    check("R8 second pass normal", 64'(t), 64'h24110302000000);
    run_case("R8 done survives write", 56'h24110301595900, 1, 56'h24110302000000);
    run_case("R8 year rollover", 56'h24123123595902, 1, 56'h25010100000003);
    run_case("R8 done cleared", 56'h25110201595900, 1, 56'h25110201000000);

    // R9 enable bit off
    wr(8, 8'h20);
    run_case("R9 rule disabled", 56'h24031001595900, 1, 56'h24031002000000);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule